// File: doc/BRIEF.md
# Depth-Cascaded FIFO Token Chain

This block builds one logical first-in/first-out queue out of a chain of identical storage slices. Each slice holds a small number of words in its own memory and keeps its own write and read pointers, occupancy count, empty flag and full flag. No slice ever holds an address wider than its own depth. Instead, two ownership tokens travel around the ring of slices. The write token marks the slice that accepts the next incoming word. The read token marks the slice that presents the oldest stored word.

When a slice writes or reads its last physical location, its expansion output raises a one-cycle hand-over pulse. The pulse is tagged as a write or a read, and the next slice in the ring takes the matching token. The slice after the last one is the first one. The slice marked first-load starts with both tokens after reset. The chain-level empty and full indications are formed by combining the per-slice flags. The output word is gathered from whichever slice currently holds the read token.

The queue has one write port and one read port on a single clock, with show-ahead read data. Replaying the queue and a half-occupancy indication are not offered in this cascaded arrangement.

Top module: `casc_fifo_chain`

## Requirements
- R1: While reset is asserted and right after its release, `rd_empty` is 1, `wr_full` is 0 and `rd_valid` is 0.
- R2: Words leave through `rd_data` in exactly the order in which they were accepted, including across slice boundaries.
- R3: After reset the first-load slice (slice 0) owns both tokens, so the first accepted word lands in slice 0 and is the first word read. At all times exactly one slice owns the write token and exactly one owns the read token.
- R4: A write to the last location of a slice hands the write token to the next slice, and from the last slice back to slice 0. The queue therefore stores `SLICES*SLICE_DEPTH` words in ring order.
- R5: A read from the last location of a slice hands the read token onward in the same ring order. Only the slice owning the read token drives `rd_data`, and at most one slice claims valid data.
- R6: `wr_full` is 1 exactly when `SLICES*SLICE_DEPTH` words are held. A write presented while `wr_full` is 1 is not stored, even when a read is accepted in the same cycle.
- R7: `rd_empty` is 1 exactly when no word is held. A read presented while `rd_empty` is 1 removes nothing, even when a write is accepted in the same cycle.
- R8: When a write and a read are both accepted in one cycle, both take effect: occupancy is unchanged and the queue order holds.
- R9: `rd_valid` equals the inverse of `rd_empty`. Whenever it is 1, `rd_data` already shows the oldest held word, before the read is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for every slice |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Request to store `wr_data` this cycle |
| wr_data | input | DATA_W | Word to store |
| wr_full | output | 1 | Chain-level full indication |
| rd_en | input | 1 | Request to remove the word on `rd_data` this cycle |
| rd_data | output | DATA_W | Oldest held word (show-ahead) |
| rd_valid | output | 1 | `rd_data` holds a word |
| rd_empty | output | 1 | Chain-level empty indication |

## Verification
Every cycle, the assertions check that each token has exactly one owner, that at most one slice claims the output bus, and that `rd_valid` and `rd_empty` agree. They also check that no slice is ever written while full or read while empty, and that the chain-level flags hold when nothing could change them. Only the bench's scenarios can show that words come back in order across slice boundaries and across the wrap from the last slice to the first. The same holds for showing that a write blocked at full or a read blocked at empty truly leaves no trace, and that simultaneous read and write keep occupancy constant.

// File: rtl/casc_fifo_pkg.sv
package casc_fifo_pkg;

   // Hand-over pulse travelling from one slice to the next in the ring.
   typedef struct packed {
      logic wr_pass;   // write token moves on
      logic rd_pass;   // read token moves on
   } hand_t;

endpackage

// File: rtl/slice_store.sv
module slice_store #(
   parameter int DATA_W = 9,
   parameter int DEPTH  = 4,
   localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [AW-1:0]     raddr,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   // show-ahead read port
   assign rdata = mem[raddr];

endmodule

// File: rtl/fifo_slice.sv
module fifo_slice
   import casc_fifo_pkg::*;
#(
   parameter int DATA_W = 9,
   parameter int DEPTH  = 4,
   localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              first_load_n,
   input  hand_t             xin,
   output hand_t             xout,
   input  logic              wr_go,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_go,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_vld,
   output logic              slc_empty,
   output logic              slc_full,
   output logic              wr_own,
   output logic              rd_own
);

   localparam logic [AW-1:0] LAST_LOC = AW'(DEPTH - 1);
   localparam logic [CW-1:0] CAP      = CW'(DEPTH);

   logic [AW-1:0] wptr, rptr;
   logic [CW-1:0] cnt;
   logic          wr_tok, rd_tok;
   logic          do_wr, do_rd, wr_last, rd_last;

   assign do_wr   = wr_go & wr_tok;
   assign do_rd   = rd_go & rd_tok;
   assign wr_last = (wptr == LAST_LOC);
   assign rd_last = (rptr == LAST_LOC);

   assign xout.wr_pass = do_wr & wr_last;
   assign xout.rd_pass = do_rd & rd_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr   <= '0;
         rptr   <= '0;
         cnt    <= '0;
         wr_tok <= ~first_load_n;
         rd_tok <= ~first_load_n;
      end else begin
         if (do_wr) wptr <= wr_last ? '0 : wptr + AW'(1);
         if (do_rd) rptr <= rd_last ? '0 : rptr + AW'(1);
         case ({do_wr, do_rd})
            2'b10:   cnt <= cnt + CW'(1);
            2'b01:   cnt <= cnt - CW'(1);
            default: cnt <= cnt;
         endcase
         // release first, then a received pulse wins (single-slice ring)
         if (xout.wr_pass) wr_tok <= 1'b0;
         if (xin.wr_pass)  wr_tok <= 1'b1;
         if (xout.rd_pass) rd_tok <= 1'b0;
         if (xin.rd_pass)  rd_tok <= 1'b1;
      end
   end

   slice_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk   (clk),
      .we    (do_wr),
      .waddr (wptr),
      .wdata (wr_data),
      .raddr (rptr),
      .rdata (rd_data)
   );

   assign slc_empty = (cnt == '0);
   assign slc_full  = (cnt == CAP);
   assign rd_vld    = rd_tok & ~slc_empty;
   assign wr_own    = wr_tok;
   assign rd_own    = rd_tok;

   // R6: the chain-level gate never lets a slice be written while it is full
   a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      do_wr |-> (cnt != CAP));

   // R7: the chain-level gate never lets a slice be read while it is empty
   a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      do_rd |-> (cnt != '0));

endmodule

// File: rtl/flag_merge.sv
module flag_merge #(
   parameter int SLICES = 3,
   parameter int DATA_W = 9
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [SLICES-1:0]              sl_empty,
   input  logic [SLICES-1:0]              sl_full,
   input  logic [SLICES-1:0]              sl_vld,
   input  logic [SLICES-1:0][DATA_W-1:0]  sl_data,
   input  logic [SLICES-1:0]              sl_wr_own,
   input  logic [SLICES-1:0]              sl_rd_own,
   output logic                           empty_c,
   output logic                           full_c,
   output logic                           vld_c,
   output logic [DATA_W-1:0]              data_c
);

   generate
      if (SLICES == 1) begin : g_single
         assign empty_c = sl_empty[0];
         assign full_c  = sl_full[0];
         assign vld_c   = sl_vld[0];
         assign data_c  = sl_data[0];
      end else begin : g_chain
         // every slice must agree for the chain-level flags
         assign empty_c = &sl_empty;
         assign full_c  = &sl_full;
         assign vld_c   = |sl_vld;
         always_comb begin
            data_c = '0;
            for (int i = 0; i < SLICES; i++)
               data_c = data_c | (sl_data[i] & {DATA_W{sl_vld[i]}});
         end
      end
   endgenerate

   // R3: exactly one owner of each token
   a_r3_wr_token_unique: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(sl_wr_own));
   a_r3_rd_token_unique: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(sl_rd_own));

   // R5: at most one slice drives the output bus
   a_r5_single_driver: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sl_vld));

   // R9: valid data and chain emptiness are complementary
   a_r9_valid_vs_empty: assert property (@(posedge clk) disable iff (!rst_n)
      vld_c == !empty_c);

endmodule

// File: rtl/casc_fifo_chain.sv
module casc_fifo_chain
   import casc_fifo_pkg::*;
#(
   parameter int SLICES      = 3,
   parameter int SLICE_DEPTH = 4,
   parameter int DATA_W      = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic              wr_full,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   output logic              rd_empty
);

   generate
      if (SLICES < 1)      begin : g_bad_slices $error("SLICES must be at least 1"); end
      if (SLICE_DEPTH < 2) begin : g_bad_depth  $error("SLICE_DEPTH must be at least 2"); end
      if (DATA_W < 1)      begin : g_bad_width  $error("DATA_W must be at least 1"); end
   endgenerate

   hand_t                          hand [SLICES];
   logic [SLICES-1:0]              sl_empty, sl_full, sl_vld, sl_wr_own, sl_rd_own;
   logic [SLICES-1:0][DATA_W-1:0]  sl_data;
   logic                           empty_c, full_c, wr_go, rd_go;

   assign wr_go = wr_en & ~full_c;
   assign rd_go = rd_en & ~empty_c;

   generate
      for (genvar i = 0; i < SLICES; i++) begin : g_slice
         localparam int PREV = (i == 0) ? SLICES - 1 : i - 1;
         fifo_slice #(.DATA_W(DATA_W), .DEPTH(SLICE_DEPTH)) u_slice (
            .clk          (clk),
            .rst_n        (rst_n),
            .first_load_n ((i == 0) ? 1'b0 : 1'b1),
            .xin          (hand[PREV]),
            .xout         (hand[i]),
            .wr_go        (wr_go),
            .wr_data      (wr_data),
            .rd_go        (rd_go),
            .rd_data      (sl_data[i]),
            .rd_vld       (sl_vld[i]),
            .slc_empty    (sl_empty[i]),
            .slc_full     (sl_full[i]),
            .wr_own       (sl_wr_own[i]),
            .rd_own       (sl_rd_own[i])
         );
      end
   endgenerate

   flag_merge #(.SLICES(SLICES), .DATA_W(DATA_W)) u_merge (
      .clk       (clk),
      .rst_n     (rst_n),
      .sl_empty  (sl_empty),
      .sl_full   (sl_full),
      .sl_vld    (sl_vld),
      .sl_data   (sl_data),
      .sl_wr_own (sl_wr_own),
      .sl_rd_own (sl_rd_own),
      .empty_c   (empty_c),
      .full_c    (full_c),
      .vld_c     (rd_valid),
      .data_c    (rd_data)
   );

   assign wr_full  = full_c;
   assign rd_empty = empty_c;

   // R6: full stays set when no read is accepted
   a_r6_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_full && !rd_go) |=> wr_full);

   // R7: empty stays set when no write is requested
   a_r7_empty_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_empty && !wr_en) |=> rd_empty);

endmodule

// File: tb/tb_casc_fifo_chain.sv
module tb_casc_fifo_chain;

   localparam int CLK_P  = 10;
   localparam int SLICES = 3;
   localparam int DEPTH  = 4;
   localparam int DW     = 9;
   localparam int CAP    = SLICES * DEPTH;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0, rd_en = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic          wr_full, rd_valid, rd_empty;
   logic [DW-1:0] rd_data;

   int checks = 0;
   int fails  = 0;
   logic [DW-1:0] model [$];

   always #(CLK_P/2) clk = ~clk;

   casc_fifo_chain #(.SLICES(SLICES), .SLICE_DEPTH(DEPTH), .DATA_W(DW)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_full(wr_full),
      .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid), .rd_empty(rd_empty)
   );

   task automatic chk(input logic ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic check_flags();
      chk(rd_empty === (model.size() == 0), "R7", int'(rd_empty), int'(model.size() == 0));
      chk(wr_full === (model.size() == CAP), "R6", int'(wr_full), int'(model.size() == CAP));
      chk(rd_valid === (model.size() != 0), "R9", int'(rd_valid), int'(model.size() != 0));
   endtask

   // one clock cycle; called at a falling edge, returns at the next one
   task automatic cyc(input logic w, input logic [DW-1:0] d, input logic r, input string tag);
      int sz = model.size();
      wr_en = w; wr_data = d; rd_en = r;
      #1;
      if (r && sz > 0) chk(rd_data === model[0], tag, int'(rd_data), int'(model[0]));
      if (w && sz < CAP) model.push_back(d);
      if (r && sz > 0) void'(model.pop_front());
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0;
      check_flags();
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      model.delete();
      repeat (2) @(negedge clk);
      // R1: reset state while held
      chk(rd_empty === 1'b1, "R1", int'(rd_empty), 1);
      chk(wr_full === 1'b0, "R1", int'(wr_full), 0);
      chk(rd_valid === 1'b0, "R1", int'(rd_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(rd_empty === 1'b1 && wr_full === 1'b0 && rd_valid === 1'b0, "R1",
          int'({rd_empty, wr_full, rd_valid}), 3'b100);
   endtask

   task automatic t_fill_drain();
      for (int i = 0; i < CAP; i++) cyc(1'b1, DW'(9'h100 + i), 1'b0, "R4");
      // R6: write while full is dropped
      cyc(1'b1, 9'h1AA, 1'b0, "R6");
      for (int i = 0; i < CAP; i++)
         cyc(1'b0, '0, 1'b1, (i == 0) ? "R3" : ((i % DEPTH) == 0) ? "R5" : "R2");
      // R7: read while empty removes nothing; next word still comes out intact
      cyc(1'b0, '0, 1'b1, "R7");
      cyc(1'b1, 9'h055, 1'b0, "R7");
      cyc(1'b0, '0, 1'b1, "R7");
   endtask

   task automatic t_wrap();
      for (int i = 0; i < 5; i++) cyc(1'b1, DW'(9'h020 + i), 1'b0, "R2");
      for (int i = 0; i < 5; i++) cyc(1'b0, '0, 1'b1, "R2");
      // fill runs through the last slice and wraps back to slice 0 (R4)
      for (int i = 0; i < CAP; i++) cyc(1'b1, DW'(9'h140 + i), 1'b0, "R4");
      for (int i = 0; i < CAP; i++) cyc(1'b0, '0, 1'b1, "R4");
   endtask

   task automatic t_simul();
      for (int i = 0; i < 6; i++) cyc(1'b1, DW'(9'h0A0 + i), 1'b0, "R2");
      for (int i = 0; i < 10; i++) begin
         cyc(1'b1, DW'(9'h0C0 + i), 1'b1, "R8");
         chk(model.size() == 6, "R8", model.size(), 6);
      end
      while (model.size() > 0) cyc(1'b0, '0, 1'b1, "R8");
   endtask

   task automatic t_full_rw();
      for (int i = 0; i < CAP; i++) cyc(1'b1, DW'(9'h180 + i), 1'b0, "R6");
      // R6: read accepted, write blocked in the same cycle
      cyc(1'b1, 9'h1EE, 1'b1, "R6");
      while (model.size() > 0) cyc(1'b0, '0, 1'b1, "R6");
   endtask

   task automatic t_empty_rw();
      // R7: write accepted, read blocked in the same cycle
      cyc(1'b1, 9'h033, 1'b1, "R7");
      cyc(1'b0, '0, 1'b1, "R7");
   endtask

   initial begin
      #(CLK_P * 100000);
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_fill_drain();
      t_wrap();
      t_simul();
      t_full_rw();
      t_empty_rw();
      t_reset();
      t_fill_drain();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule